// File: doc/BRIEF.md
# SPI Slave Word Exchange Port

This block is the slave end of a four-wire serial link. It watches the serial clock, the master-to-slave data line and an active-low select from inside the system clock domain. While selected, it shifts one word in from the master and one word out to the master at the same time, so the two sides swap words. The clock idle level and the edge on which data is captured are chosen by two configuration inputs, which together give four transfer modes.

On the parallel side, a one-word holding register takes the next outgoing word through a valid/ready handshake. `tx_ready` is high while the holding register is empty. A word is taken when `tx_valid` and `tx_ready` are both high at a rising clock edge. Received words leave through `rx_data` with a one-cycle `rx_valid` strobe. The receive side cannot stall the link, because the master owns the clock. The consumer must therefore take each word in the cycle it is strobed. The next strobe may overwrite it.

While deselected, the port takes no notice of clock or data activity, and it drops its output enable so other slaves can drive the shared return line. All three serial inputs pass through a two-flop synchronizer. The serial clock must run well below the system clock.

Top module: `spi_slave_port`

## Requirements
- R1: `spi_miso_oe` is low while `spi_csn` is high. It goes high within four system clocks after `spi_csn` goes low, and it stays high while `spi_csn` stays low.
- R2: While `spi_csn` is high, toggling `spi_sclk` and `spi_mosi` produces no `rx_valid` and does not consume the word in the holding register.
- R3: Each word is full duplex. For each group of WORD_W capture edges, WORD_W bits are taken from `spi_mosi` and WORD_W bits are sent on `spi_miso`. `rx_data` equals the master's word, with the first captured bit in bit WORD_W-1.
- R4: The slave sends the word it loaded most significant bit first, one bit per capture edge.
- R5: Mode bits: `cfg_cpol` is the idle level of `spi_sclk`, and the leading edge is the transition away from that level. With `cfg_cpha`=0, data is captured on leading edges and changed on trailing edges. With `cfg_cpha`=1, data is changed on leading edges and captured on trailing edges.
- R6: With `cfg_cpha`=0, the most significant bit of the loaded word is on `spi_miso` before the first clock edge after select falls.
- R7: While select stays low, words follow each other with no gap. Each word loads the next entry from the holding register.
- R8: When select rises in the middle of a word, the partial bits are dropped, no `rx_valid` is produced, and the next frame starts from bit zero.
- R9: `rx_valid` is high for exactly one system clock per completed word, and `rx_data` changes only in that cycle.
- R10: `tx_ready` is high exactly when the holding register is empty. An accepted word makes it low in the next cycle. If a word starts while the holding register is empty, all zeros are sent.
- R11: After reset, `tx_ready`=1, `rx_valid`=0 and `spi_miso_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, valid while enabled |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` |
| tx_data | input | WORD_W | Next word to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | WORD_W | Last word received |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |

## Verification
The bench runs all four modes, with single-word frames, three-word frames and an underfed frame. It computes each expected word arithmetically. A mode decoder with swapped edges would corrupt every bit. A missing reload between back-to-back words would repeat or shift the previous word. A slave that counts clock edges while deselected would misalign the next frame, or would use up the pending transmit word. A bit counter that is not cleared on deselect would make a partial word leak into the next one as a wrong `rx_data`. For CPHA=0, the first bit is checked before any clock edge, which catches a slave that loads its word late.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic capture;
    logic launch;
  } spi_edge_t;

  // Map raw clock transitions to capture/launch strobes for the active mode.
  function automatic spi_edge_t pick_edges(input logic rise, input logic fall,
                                           input logic cpol, input logic cpha);
    spi_edge_t e;
    logic lead;
    logic trail;
    lead  = cpol ? fall : rise;
    trail = cpol ? rise : fall;
    e.capture = cpha ? trail : lead;
    e.launch  = cpha ? lead  : trail;
    return e;
  endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int unsigned       WIDTH  = 1,
  parameter int unsigned       STAGES = 2,
  parameter logic [WIDTH-1:0]  INIT   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{INIT}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[LAST];
endmodule

// File: rtl/spi_port_edges.sv
module spi_port_edges
  import spi_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic sel_n_s,
  input  logic cpol,
  input  logic cpha,
  output logic capture,
  output logic launch,
  output logic sel_fall
);
  logic      sclk_q;
  logic      sel_q;
  spi_edge_t ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= sel_n_s;
    end
  end

  always_comb begin
    ev = pick_edges(sclk_s & ~sclk_q, ~sclk_s & sclk_q, cpol, cpha);
  end

  assign capture  = ev.capture & ~sel_n_s;
  assign launch   = ev.launch  & ~sel_n_s;
  assign sel_fall = sel_q & ~sel_n_s;
endmodule

// File: rtl/spi_port_txhold.sv
module spi_port_txhold #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] data
);
  wire accept = in_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        data <= in_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  assign in_ready = ~full;
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_fall,
  input  logic              cpha,
  input  logic              capture,
  input  logic              launch,
  input  logic              mosi,
  input  logic              hold_full,
  input  logic [WORD_W-1:0] hold_data,
  output logic              load_now,
  output logic              miso,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              reload;
  logic [WORD_W-1:0] next_word;

  assign next_word = hold_full ? hold_data : '0;
  assign load_now  = ~sel_n & ((sel_fall & ~cpha) | (launch & reload));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      bit_cnt  <= '0;
      reload   <= 1'b1;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sel_n) begin
        bit_cnt <= '0;
        reload  <= 1'b1;
      end else begin
        if (sel_fall) begin
          reload <= cpha;
          if (!cpha) tx_sh <= next_word;
        end
        if (capture) begin
          rx_sh <= {rx_sh[WORD_W-2:0], mosi};
          if (bit_cnt == LAST_BIT) begin
            rx_data  <= {rx_sh[WORD_W-2:0], mosi};
            rx_valid <= 1'b1;
            bit_cnt  <= '0;
            reload   <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (launch) begin
          if (reload) begin
            tx_sh  <= next_word;
            reload <= 1'b0;
          end else begin
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso = tx_sh[WORD_W-1];
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port #(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int unsigned NSIG = 3;
  localparam logic [NSIG-1:0] SYNC_INIT = 3'b100;

  logic [NSIG-1:0]   raw_in;
  logic [NSIG-1:0]   sync_out;
  logic              sclk_s, mosi_s, sel_n_s;
  logic              capture, launch, sel_fall;
  logic              hold_full, load_now;
  logic [WORD_W-1:0] hold_data;

  assign raw_in = {spi_csn, spi_mosi, spi_sclk};
  assign {sel_n_s, mosi_s, sclk_s} = sync_out;

  spi_port_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  spi_port_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sel_n_s(sel_n_s),
    .cpol(cfg_cpol), .cpha(cfg_cpha),
    .capture(capture), .launch(launch), .sel_fall(sel_fall)
  );

  spi_port_txhold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_data(tx_data), .in_valid(tx_valid),
    .in_ready(tx_ready), .take(load_now), .full(hold_full), .data(hold_data)
  );

  spi_port_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n_s), .sel_fall(sel_fall),
    .cpha(cfg_cpha), .capture(capture), .launch(launch), .mosi(mosi_s),
    .hold_full(hold_full), .hold_data(hold_data), .load_now(load_now),
    .miso(spi_miso), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assign spi_miso_oe = ~sel_n_s;
endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_csn,
  input logic              spi_miso_oe,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_valid
);
  // R1: select held high for four cycles means the line is released
  a_r1_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_miso_oe);

  // R2: no received word while deselected
  a_r2_no_word_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3) && $past(spi_csn, 4))
      |-> !rx_valid);

  // R9: strobe lasts one cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9: received data only changes with its strobe
  a_r9_data_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid);

  // R10: an accepted word fills the holding register
  a_r10_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind spi_slave_port spi_slave_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_miso_oe(spi_miso_oe),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid)
);

// File: tb/spi_slave_port_test.sv
`timescale 1ns/1ps
module spi_slave_port_test;
  localparam int W = 8;
  localparam int H = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic         spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic         spi_miso, spi_miso_oe;
  logic [W-1:0] tx_data = '0;
  logic         tx_valid = 1'b0;
  logic         tx_ready;
  logic [W-1:0] rx_data;
  logic         rx_valid;

  int total = 0;
  int fails = 0;
  int rx_cnt = 0;
  int dbl = 0;
  logic         prev_v = 1'b0;
  logic [W-1:0] rx_log [64];
  logic [W-1:0] txw [4];
  logic [W-1:0] mow [4];

  always #5 clk = ~clk;

  spi_slave_port #(.WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      if (rx_cnt < 64) rx_log[rx_cnt] = rx_data;
      rx_cnt = rx_cnt + 1;
      if (prev_v) dbl = dbl + 1;
    end
    prev_v = rx_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] w);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic set_mode(input int m);
    cfg_cpol = m[1];
    cfg_cpha = m[0];
    spi_sclk = m[1];
    repeat (8) @(negedge clk);
  endtask

  // Frame of n words; words 0..npush-1 are offered (word 0 before select
  // unless already preloaded); missing words are expected as zero (R10).
  task automatic run_frame(input int n, input int npush, input bit preloaded);
    int base;
    base = rx_cnt;
    if (!preloaded) push(txw[0]);
    @(negedge clk);
    spi_csn = 1'b0;
    fork
      begin
        for (int k = 1; k < npush; k++) push(txw[k]);
      end
      begin
        logic [W-1:0] mi;
        logic [W-1:0] exp_w;
        if (!cfg_cpha) spi_mosi = mow[0][W-1];
        repeat (H) @(negedge clk);
        check(spi_miso_oe == 1'b1, "R1 oe while selected", spi_miso_oe, 1);
        if (!cfg_cpha)
          check(spi_miso == txw[0][W-1], "R6 first bit before any edge", spi_miso, txw[0][W-1]);
        for (int k = 0; k < n; k++) begin
          mi = '0;
          for (int b = W - 1; b >= 0; b--) begin
            if (!cfg_cpha) begin
              spi_sclk = ~cfg_cpol;
              mi[b] = spi_miso;
              repeat (H) @(negedge clk);
              spi_sclk = cfg_cpol;
              if (b > 0) spi_mosi = mow[k][b-1];
              else if (k + 1 < n) spi_mosi = mow[k+1][W-1];
              repeat (H) @(negedge clk);
            end else begin
              spi_sclk = ~cfg_cpol;
              spi_mosi = mow[k][b];
              repeat (H) @(negedge clk);
              spi_sclk = cfg_cpol;
              mi[b] = spi_miso;
              repeat (H) @(negedge clk);
            end
          end
          exp_w = (k < npush) ? txw[k] : '0;
          // R4 MSB-first transmit, R5 mode edges, R7 back-to-back, R10 zero fill
          check(mi == exp_w, "R4/R5/R7/R10 miso word", mi, exp_w);
        end
      end
    join
    repeat (H) @(negedge clk);
    spi_csn = 1'b1;
    repeat (6) @(negedge clk);
    check(spi_miso_oe == 1'b0, "R1 released after deselect", spi_miso_oe, 0);
    check(rx_cnt - base == n, "R3 word count", rx_cnt - base, n);
    for (int k = 0; k < n; k++)
      if (base + k < 64)
        check(rx_log[base+k] == mow[k], "R3 rx word", rx_log[base+k], mow[k]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R7 watchdog act=running exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    check(tx_ready == 1'b1, "R11 tx_ready", tx_ready, 1);
    check(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
    check(spi_miso_oe == 1'b0, "R11 oe", spi_miso_oe, 0);

    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      for (int k = 0; k < 4; k++) begin
        txw[k] = W'((m * 37 + k * 29 + 11) & 8'hFF);
        mow[k] = W'((m * 71 + k * 13 + 8'hA5) & 8'hFF);
      end
      run_frame(1, 1, 1'b0);
      run_frame(3, 3, 1'b0);   // R7 continuous stream
      txw[0] = ~txw[0];
      run_frame(2, 1, 1'b0);   // R10 second word unfed -> zeros
    end

    // R2: activity while deselected is ignored
    set_mode(0);
    push(8'h3C);
    check(tx_ready == 1'b0, "R10 holding full after accept", tx_ready, 0);
    c0 = rx_cnt;
    for (int i = 0; i < 20; i++) begin
      spi_sclk = ~spi_sclk;
      spi_mosi = i[0] ^ i[2];
      repeat (3) @(negedge clk);
    end
    spi_sclk = 1'b0;
    repeat (6) @(negedge clk);
    check(rx_cnt == c0, "R2 no word while idle", rx_cnt - c0, 0);
    check(tx_ready == 1'b0, "R2 holding not consumed", tx_ready, 0);
    check(spi_miso_oe == 1'b0, "R1 oe idle during activity", spi_miso_oe, 1'b0);
    txw[0] = 8'h3C;
    mow[0] = 8'h96;
    run_frame(1, 1, 1'b1);

    // R8: partial word dropped
    set_mode(1);
    c0 = rx_cnt;
    spi_csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      spi_sclk = 1'b1; spi_mosi = 1'b1;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    spi_csn = 1'b1;
    repeat (8) @(negedge clk);
    check(rx_cnt == c0, "R8 no word from partial", rx_cnt - c0, 0);
    txw[0] = 8'h5A;
    mow[0] = 8'h0F;
    run_frame(1, 1, 1'b0);

    check(dbl == 0, "R9 strobe width", dbl, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule